// File: doc/BRIEF.md
# DMA Request Pacing Timer

This block raises transfer requests for each channel of a multi-channel DMA controller while a block move between two memory areas is in progress. Each channel owns a 4-bit interval code that software writes and reads back through a small register port. The code picks how the channel's requests are produced. It can forward rising edges seen on an external request line. It can hold a request up back to back until the block ends. It can also leave a fixed gap of clocks after every acknowledge, and that gap grows by 32 cycles per code step.

Only the first two channels can produce paced or continuous requests. The remaining channels always work from their external request line, whatever code is stored for them. Every external line passes through a two-flop synchronizer, and one request is produced for each rising edge that arrives while the channel is waiting. Each channel runs a four-state machine. In IDLE there is no block in progress. In ARM the channel waits for an external edge. In REQ the request is held until it is acknowledged. In GAP the pacing counter is running.

The transitions are these. IDLE goes to ARM when the block starts and the effective code is 0, and goes to REQ for any other code. ARM goes to REQ on a synchronized edge. REQ goes to ARM, REQ or GAP on acknowledge, for effective code 0, 1 and 2 or more respectively. GAP goes to REQ when the counter reaches the programmed gap. Dropping the block-active flag sends the channel from any state to IDLE and clears the counter.

Top module: `dma_pace_timer`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into the interval register of channel `wr_ch` at the clock edge. `rd_data` shows the register of channel `rd_ch` combinationally, so a written value is visible from the cycle after the write.
- R2: Reset sets every interval register to 0 and holds every `req` bit low.
- R3: With effective code 0 in the ARM state, a rising edge on `ext_req[i]` is seen at the third clock edge after it is applied, and `req[i]` goes high after that edge. Edges that arrive while `req[i]` is already high are dropped.
- R4: With code 1 on channel 0 or 1, `req[i]` stays high through acknowledges for as long as `blk_active[i]` stays high.
- R5: With code c from 2 to 15 on channel 0 or 1, an acknowledge sampled at an edge drops `req[i]` for exactly (c-1)*32 clock cycles. `req[i]` then rises again (c=2 gives 32 cycles, c=15 gives 448).
- R6: With code 1 to 15 on channel 0 or 1, the first request of a block is raised at the first clock edge at which `blk_active[i]` is seen high.
- R7: Channels 2 and 3 treat any stored code as 0. They raise no request without an external edge, and they drop `req` after each acknowledge.
- R8: When `blk_active[i]` is low at an edge, `req[i]` is low after that edge, and the gap counter restarts from zero on the next block.
- R9: Once high, `req[i]` stays high until an acknowledge or the end of the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Interval register write strobe |
| wr_ch | input | 2 | Channel selected for the write |
| wr_data | input | 4 | Interval code to store |
| rd_ch | input | 2 | Channel selected for readback |
| rd_data | output | 4 | Interval code of channel `rd_ch` |
| ext_req | input | 4 | Asynchronous external request lines, one per channel |
| blk_active | input | 4 | Block move in progress, one per channel |
| req_ack | input | 4 | Request acknowledge, one per channel |
| req | output | 4 | Transfer request, one per channel |

## Verification
Each result has a fixed delay from its stimulus. A register write shows on readback one edge later. A block start raises a paced or continuous request one edge later, and a drop of the block-active flag clears the request one edge later. An external edge produces a request after three edges, and an acknowledged paced request returns exactly (code-1)*32 edges after the acknowledge edge. The bench drives inputs on the falling edge and samples on a later falling edge. At the output it checks both the last cycle in which the result must still be absent and the first cycle in which it must be present, so an off-by-one in any of these delays is caught.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ARM  = 2'd1,
        S_REQ  = 2'd2,
        S_GAP  = 2'd3
    } chan_state_e;
endpackage

// File: rtl/dpt_sync.sv
module dpt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign rise_pulse = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/dpt_regs.sv
module dpt_regs #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 4,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [CH_W-1:0]          wr_ch,
    input  logic [CODE_W-1:0]        wr_data,
    input  logic [CH_W-1:0]          rd_ch,
    output logic [CODE_W-1:0]        rd_data,
    output logic [NUM_CH*CODE_W-1:0] codes
);
    logic [CODE_W-1:0] code_q [NUM_CH];

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n)
                    code_q[c] <= '0;
                else if (wr_en && (wr_ch == CH_W'(c)))
                    code_q[c] <= wr_data;
            end
            assign codes[c*CODE_W +: CODE_W] = code_q[c];
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_ch == CH_W'(c)) rd_data = code_q[c];
        end
    end
endmodule

// File: rtl/dpt_chan_fsm.sv
module dpt_chan_fsm
    import dpt_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int STEP   = 32,
    parameter bit PACED  = 1'b1,
    parameter int GAP_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic              blk_active,
    input  logic              ext_edge,
    input  logic              ack,
    output logic              req
);
    chan_state_e       state_q, state_d;
    logic [GAP_W-1:0]  cnt_q, cnt_d;
    logic [CODE_W-1:0] eff_code;
    logic [GAP_W-1:0]  gap_len;
    logic              gap_done;

    // Channels without pacing always run as externally triggered
    assign eff_code = PACED ? code : '0;
    assign gap_len  = GAP_W'(eff_code - CODE_W'(1)) * GAP_W'(STEP);
    assign gap_done = (cnt_q >= gap_len - GAP_W'(1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and gap counter
    always_comb begin
        state_d = state_q;
        if (!blk_active) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: state_d = (eff_code == '0) ? S_ARM : S_REQ;
                S_ARM:  if (ext_edge) state_d = S_REQ;
                S_REQ: begin
                    if (ack) begin
                        if (eff_code == '0)                state_d = S_ARM;
                        else if (eff_code == CODE_W'(1))   state_d = S_REQ;
                        else                               state_d = S_GAP;
                    end
                end
                S_GAP: begin
                    if (eff_code == '0)                    state_d = S_ARM;
                    else if (eff_code == CODE_W'(1))       state_d = S_REQ;
                    else if (gap_done)                     state_d = S_REQ;
                end
                default: state_d = S_IDLE;
            endcase
        end
        cnt_d = (state_q == S_GAP && state_d == S_GAP) ? cnt_q + GAP_W'(1) : '0;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            S_REQ:   req = 1'b1;
            default: req = 1'b0;
        endcase
    end
endmodule

// File: rtl/dma_pace_timer.sv
module dma_pace_timer #(
    parameter int NUM_CH    = 4,
    parameter int NUM_PACED = 2,
    parameter int CODE_W    = 4,
    parameter int STEP      = 32,
    parameter int SYNC_LEN  = 2,
    parameter int CH_W      = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [CODE_W-1:0] wr_data,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [CODE_W-1:0] rd_data,
    input  logic [NUM_CH-1:0] ext_req,
    input  logic [NUM_CH-1:0] blk_active,
    input  logic [NUM_CH-1:0] req_ack,
    output logic [NUM_CH-1:0] req
);
    localparam int MAX_GAP = ((1 << CODE_W) - 2) * STEP;
    localparam int GAP_W   = $clog2(MAX_GAP + 1);

    logic [NUM_CH*CODE_W-1:0] codes;
    logic [NUM_CH-1:0]        ext_edge;

    dpt_regs #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .CH_W(CH_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_data(wr_data), .rd_ch(rd_ch), .rd_data(rd_data), .codes(codes)
    );

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            dpt_sync #(.STAGES(SYNC_LEN)) u_sync (
                .clk(clk), .rst_n(rst_n),
                .async_in(ext_req[i]), .rise_pulse(ext_edge[i])
            );
            dpt_chan_fsm #(
                .CODE_W(CODE_W), .STEP(STEP),
                .PACED(i < NUM_PACED), .GAP_W(GAP_W)
            ) u_fsm (
                .clk(clk), .rst_n(rst_n),
                .code(codes[i*CODE_W +: CODE_W]),
                .blk_active(blk_active[i]), .ext_edge(ext_edge[i]),
                .ack(req_ack[i]), .req(req[i])
            );
        end
    endgenerate
endmodule

// File: rtl/dpt_checker.sv
module dpt_checker #(
    parameter int NUM_CH    = 4,
    parameter int NUM_PACED = 2,
    parameter int CODE_W    = 4,
    parameter int CH_W      = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [CH_W-1:0]   wr_ch,
    input logic [CODE_W-1:0] wr_data,
    input logic [CH_W-1:0]   rd_ch,
    input logic [CODE_W-1:0] rd_data,
    input logic [NUM_CH-1:0] ext_req,
    input logic [NUM_CH-1:0] blk_active,
    input logic [NUM_CH-1:0] req_ack,
    input logic [NUM_CH-1:0] req
);
    assert_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && $past(rst_n) && rd_ch == $past(wr_ch) && !wr_en) |-> rd_data == $past(wr_data));

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
            assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !blk_active[i] |=> !req[i]);
            assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (req[i] && !req_ack[i] && blk_active[i]) |=> req[i]);
            if (i >= NUM_PACED) begin : g_ext_only
                assert_ack_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
                    (req[i] && req_ack[i]) |=> !req[i]);
                assert_edge_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
                    $rose(req[i]) |-> $past(ext_req[i], 3));
            end
        end
    endgenerate
endmodule

bind dma_pace_timer dpt_checker #(
    .NUM_CH(NUM_CH), .NUM_PACED(NUM_PACED), .CODE_W(CODE_W), .CH_W(CH_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .rd_ch(rd_ch), .rd_data(rd_data), .ext_req(ext_req),
    .blk_active(blk_active), .req_ack(req_ack), .req(req)
);

// File: tb/dma_pace_timer_tb.sv
module dma_pace_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_ch = '0;
    logic [3:0] wr_data = '0;
    logic [1:0] rd_ch = '0;
    logic [3:0] rd_data;
    logic [3:0] ext_req = '0;
    logic [3:0] blk_active = '0;
    logic [3:0] req_ack = '0;
    logic [3:0] req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dma_pace_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
        .rd_ch(rd_ch), .rd_data(rd_data), .ext_req(ext_req),
        .blk_active(blk_active), .req_ack(req_ack), .req(req)
    );

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic write_code(input int ch, input int val);
        wr_en = 1'b1; wr_ch = 2'(ch); wr_data = 4'(val);
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        for (int c = 0; c < 4; c++) begin
            rd_ch = 2'(c); #1;
            check(int'(rd_data), 0, "R2 register cleared");
        end
        check(int'(req), 0, "R2 requests low");
    endtask

    task automatic t_regs;
        for (int c = 0; c < 4; c++) write_code(c, 9 + c);
        for (int c = 0; c < 4; c++) begin
            rd_ch = 2'(c); #1;
            check(int'(rd_data), 9 + c, "R1 readback");
        end
        write_code(2, 5);
        rd_ch = 2'd2; #1;
        check(int'(rd_data), 5, "R1 overwrite");
    endtask

    task automatic t_ext;
        write_code(0, 0);
        blk_active[0] = 1'b1;
        step(3);
        check(int'(req[0]), 0, "R3 no request before edge");
        ext_req[0] = 1'b1;
        step(2);
        check(int'(req[0]), 0, "R3 request not yet after two edges");
        step(1);
        check(int'(req[0]), 1, "R3 request after third edge");
        ext_req[0] = 1'b0;
        step(2);
        ext_req[0] = 1'b1;
        step(4);
        ext_req[0] = 1'b0;
        step(3);
        check(int'(req[0]), 1, "R9 request held without ack");
        req_ack[0] = 1'b1;
        step(1);
        req_ack[0] = 1'b0;
        check(int'(req[0]), 0, "R3 request dropped after ack");
        step(6);
        check(int'(req[0]), 0, "R3 edge during pending request dropped");
        blk_active[0] = 1'b0;
        step(2);
    endtask

    task automatic t_cont;
        write_code(1, 1);
        blk_active[1] = 1'b1;
        check(int'(req[1]), 0, "R6 no request before start edge");
        step(1);
        check(int'(req[1]), 1, "R6 first request one edge after start");
        req_ack[1] = 1'b1;
        step(5);
        check(int'(req[1]), 1, "R4 continuous through acks");
        req_ack[1] = 1'b0;
        blk_active[1] = 1'b0;
        step(1);
        check(int'(req[1]), 0, "R8 request cleared at block end");
        step(1);
    endtask

    task automatic t_paced(input int ch, input int code);
        int gap;
        gap = (code - 1) * 32;
        write_code(ch, code);
        blk_active[ch] = 1'b1;
        step(1);
        check(int'(req[ch]), 1, "R6 paced first request");
        req_ack[ch] = 1'b1;
        step(1);
        req_ack[ch] = 1'b0;
        check(int'(req[ch]), 0, "R5 request low after ack");
        step(gap - 1);
        check(int'(req[ch]), 0, "R5 still low at last gap cycle");
        step(1);
        check(int'(req[ch]), 1, "R5 request returns after gap");
        blk_active[ch] = 1'b0;
        step(2);
    endtask

    task automatic t_fixed;
        write_code(2, 3);
        write_code(3, 1);
        blk_active[3:2] = 2'b11;
        step(5);
        check(int'(req[3:2]), 0, "R7 no paced request on ch2/ch3");
        ext_req[3] = 1'b1;
        step(3);
        check(int'(req[3:2]), 2, "R7 ch3 request from external edge");
        ext_req[3] = 1'b0;
        req_ack[3] = 1'b1;
        step(1);
        req_ack[3] = 1'b0;
        check(int'(req[3]), 0, "R7 ch3 drops after ack despite code 1");
        blk_active[3:2] = 2'b00;
        step(2);
    endtask

    task automatic t_drop;
        write_code(0, 3);
        blk_active[0] = 1'b1;
        step(1);
        req_ack[0] = 1'b1;
        step(1);
        req_ack[0] = 1'b0;
        step(40);
        blk_active[0] = 1'b0;
        step(1);
        check(int'(req[0]), 0, "R8 request low after block drop");
        blk_active[0] = 1'b1;
        step(1);
        check(int'(req[0]), 1, "R8 fresh start raises request");
        req_ack[0] = 1'b1;
        step(1);
        req_ack[0] = 1'b0;
        step(63);
        check(int'(req[0]), 0, "R8 counter restarted from zero");
        step(1);
        check(int'(req[0]), 1, "R8 full gap after restart");
        blk_active[0] = 1'b0;
        step(2);
    endtask

    initial begin
        step(3);
        t_reset;
        rst_n = 1'b1;
        step(1);
        t_regs;
        t_ext;
        t_cont;
        t_paced(0, 2);
        t_paced(1, 15);
        t_fixed;
        t_drop;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule